// File: doc/BRIEF.md
# Doorbell Command Mailbox Target

This block is the responder side of a two-register mailbox. A host hands a command to an internal handler by first loading the data register with an argument. It then writes the command/status register with the doorbell (busy) flag set. That write latches an 8-bit command, an 8-bit sub-command and a 14-bit parameter, and raises a level request toward a handler port. The data register is presented to the handler alongside the request.

While the command is outstanding, the host polls the command/status register and sees the busy flag high. Host writes to either register are dropped during this time, so the request cannot be changed under the handler. The handler ends the command by pulsing an acknowledge that carries a completion code and a response word. In the next cycle the busy flag clears and the completion code replaces the low byte of the command/status register. If the code is zero (success), the response word also replaces the data register, and the host reads it from there.

Top module: `mbox_target`

## Requirements
- R1: After reset, the busy flag is 0, the request output is low, and both registers read back as zero.
- R2: A host write to the command/status register (address 0) with bit 31 set, while busy is 0, makes bit 31 read 1 from the next cycle. The same write raises the handler request and presents the command (bits 7:0), sub-command (bits 15:8) and parameter (bits 29:16) of the written word on the handler outputs.
- R3: While a request is raised, the handler data output equals the data register's contents at the moment the command started.
- R4: A host write to the command/status register with bit 31 clear, while idle, stores the three fields, raises no request, and reads back with bits 31 and 30 as 0.
- R5: A handler acknowledge while busy clears busy and the request in the next cycle. From then on, bits 7:0 of the command/status register hold the completion code, and bits 29:8 keep the request's fields.
- R6: When the completion code is zero, the data register (address 1) reads the handler's response word after busy clears.
- R7: When the completion code is non-zero, the data register keeps its earlier contents.
- R8: While busy is 1, host writes to either register are ignored. This includes a write that lands in the same cycle as the acknowledge.
- R9: An acknowledge while busy is 0 changes no register.
- R10: A host write to the data register while idle is stored and read back at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 1 | Register select: 0 command/status, 1 data |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data of the selected register |
| hnd_req_o | output | 1 | Request to handler, high while busy |
| hnd_cmd_o | output | 8 | Latched command |
| hnd_sub_o | output | 8 | Latched sub-command |
| hnd_param_o | output | 14 | Latched parameter |
| hnd_data_o | output | 32 | Request data (data register) |
| hnd_ack_i | input | 1 | Handler completion pulse |
| hnd_code_i | input | 8 | Completion code, 0 = success |
| hnd_resp_i | input | 32 | Response word |

## Verification
The completion from the handler and a host write can meet in one clock edge. The bench provokes this by driving the acknowledge and a doorbell write to the command register in the same cycle. The write must be dropped because busy is still high in that cycle. Afterwards, the bench expects busy low, the completion code in the low byte, the response word in the data register, and no new request raised by the dropped doorbell.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned SUB_W   = 8;
  localparam int unsigned PARAM_W = 14;

  typedef enum logic {
    ADDR_CMD  = 1'b0,
    ADDR_DATA = 1'b1
  } mbox_addr_e;
endpackage

// File: rtl/mbox_cmd_reg.sv
module mbox_cmd_reg #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned SUB_W   = 8,
  parameter int unsigned PARAM_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               ack_i,
  input  logic [CMD_W-1:0]   code_i,
  output logic               busy_o,
  output logic [CMD_W-1:0]   low_o,
  output logic [SUB_W-1:0]   sub_o,
  output logic [PARAM_W-1:0] param_o,
  output logic [DATA_W-1:0]  word_o
);
  localparam int unsigned SUB_LSB   = CMD_W;
  localparam int unsigned PARAM_LSB = CMD_W + SUB_W;
  localparam int unsigned BUSY_BIT  = DATA_W - 1;

  logic               busy_q;
  logic [CMD_W-1:0]   low_q;
  logic [SUB_W-1:0]   sub_q;
  logic [PARAM_W-1:0] param_q;
  logic               accept_wr;
  logic               finish;

  assign accept_wr = wr_i && !busy_q;
  assign finish    = ack_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      low_q   <= '0;
      sub_q   <= '0;
      param_q <= '0;
    end else if (accept_wr) begin
      busy_q  <= wdata_i[BUSY_BIT];
      low_q   <= wdata_i[CMD_W-1:0];
      sub_q   <= wdata_i[SUB_LSB +: SUB_W];
      param_q <= wdata_i[PARAM_LSB +: PARAM_W];
    end else if (finish) begin
      busy_q <= 1'b0;
      low_q  <= code_i;
    end
  end

  logic unused_bits;
  assign unused_bits = ^wdata_i[BUSY_BIT-1 : PARAM_LSB+PARAM_W];

  always_comb begin
    word_o = '0;
    word_o[BUSY_BIT]                = busy_q;
    word_o[PARAM_LSB +: PARAM_W]    = param_q;
    word_o[SUB_LSB +: SUB_W]        = sub_q;
    word_o[CMD_W-1:0]               = low_q;
  end

  assign busy_o  = busy_q;
  assign low_o   = low_q;
  assign sub_o   = sub_q;
  assign param_o = param_q;

  AST_DOORBELL_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o && wdata_i[BUSY_BIT]) |=> (busy_o && low_o == $past(wdata_i[CMD_W-1:0]))) else $error("doorbell"); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && busy_o) |=> (!busy_o && low_o == $past(code_i))) else $error("ack"); // R5
  AST_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ack_i) |=> ($stable(low_o) && $stable(sub_o) && $stable(param_o) && busy_o)) else $error("held"); // R8
  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !wr_i) |=> ($stable(word_o))) else $error("idle ack"); // R9
endmodule

// File: rtl/mbox_data_reg.sv
module mbox_data_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CMD_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic [CMD_W-1:0]  code_i,
  input  logic [DATA_W-1:0] resp_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q;
  logic              load_resp;

  assign load_resp = busy_i && ack_i && (code_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                data_q <= '0;
    else if (load_resp)         data_q <= resp_i;
    else if (wr_i && !busy_i)   data_q <= wdata_i;
  end

  assign data_o = data_q;

  AST_RESP_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ack_i && code_i == '0) |=> (data_o == $past(resp_i))) else $error("resp"); // R6
  AST_FAIL_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ack_i && code_i != '0) |=> $stable(data_o)) else $error("fail keep"); // R7
  AST_BUSY_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !ack_i) |=> $stable(data_o)) else $error("busy drop"); // R8
endmodule

// File: rtl/mbox_target.sv
module mbox_target
  import mbox_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic               host_addr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  output logic [DATA_W-1:0]  host_rdata_o,
  output logic               hnd_req_o,
  output logic [CMD_W-1:0]   hnd_cmd_o,
  output logic [SUB_W-1:0]   hnd_sub_o,
  output logic [PARAM_W-1:0] hnd_param_o,
  output logic [DATA_W-1:0]  hnd_data_o,
  input  logic               hnd_ack_i,
  input  logic [CMD_W-1:0]   hnd_code_i,
  input  logic [DATA_W-1:0]  hnd_resp_i
);
  logic              busy;
  logic              wr_cmd;
  logic              wr_data;
  logic [DATA_W-1:0] cmd_word;
  logic [DATA_W-1:0] data_word;

  assign wr_cmd  = host_we_i && (host_addr_i == ADDR_CMD);
  assign wr_data = host_we_i && (host_addr_i == ADDR_DATA);

  mbox_cmd_reg #(
    .DATA_W(DATA_W), .CMD_W(CMD_W), .SUB_W(SUB_W), .PARAM_W(PARAM_W)
  ) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_cmd),
    .wdata_i (host_wdata_i),
    .ack_i   (hnd_ack_i),
    .code_i  (hnd_code_i),
    .busy_o  (busy),
    .low_o   (hnd_cmd_o),
    .sub_o   (hnd_sub_o),
    .param_o (hnd_param_o),
    .word_o  (cmd_word)
  );

  mbox_data_reg #(
    .DATA_W(DATA_W), .CMD_W(CMD_W)
  ) u_data (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy),
    .wr_i    (wr_data),
    .wdata_i (host_wdata_i),
    .ack_i   (hnd_ack_i),
    .code_i  (hnd_code_i),
    .resp_i  (hnd_resp_i),
    .data_o  (data_word)
  );

  assign hnd_req_o    = busy;
  assign hnd_data_o   = data_word;
  assign host_rdata_o = (host_addr_i == ADDR_DATA) ? data_word : cmd_word;

  AST_REQ_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hnd_req_o && !hnd_ack_i) |=> $stable(hnd_data_o)) else $error("req data"); // R3
  AST_NO_START_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hnd_req_o && wr_cmd && !host_wdata_i[DATA_W-1]) |=> !hnd_req_o) else $error("no start"); // R4
  AST_IDLE_DATA_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hnd_req_o && wr_data) |=> (hnd_data_o == $past(host_wdata_i))) else $error("data wr"); // R10
endmodule

// File: tb/mbox_target_tb.sv
`timescale 1ns/1ps
module mbox_target_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;
  logic [7:0]  hcmd, hsub;
  logic [13:0] hparam;
  logic [31:0] hdata;
  logic        ack = 1'b0;
  logic [7:0]  code = '0;
  logic [31:0] resp = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0]  c;
    logic [7:0]  s;
    logic [13:0] p;
    logic [31:0] d;
  } req_t;
  req_t exp_q[$];

  always #10 clk = ~clk;

  mbox_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .hnd_req_o(req),
    .hnd_cmd_o(hcmd), .hnd_sub_o(hsub), .hnd_param_o(hparam), .hnd_data_o(hdata),
    .hnd_ack_i(ack), .hnd_code_i(code), .hnd_resp_i(resp)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(string tag, logic a, logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic start(logic [31:0] d, logic [31:0] cw);
    req_t e;
    wr(1'b1, d);
    e.c = cw[7:0]; e.s = cw[15:8]; e.p = cw[29:16]; e.d = d;
    exp_q.push_back(e);
    wr(1'b0, cw);
  endtask

  task automatic do_ack(logic [7:0] c, logic [31:0] r);
    @(negedge clk); ack = 1'b1; code = c; resp = r;
    @(negedge clk); ack = 1'b0;
  endtask

  // monitor: compare each new handler request against the scoreboard
  logic req_d = 1'b0;
  always @(negedge clk) begin
    if (req && !req_d) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected request act=%h exp=none", {hcmd, hsub, hparam});
      end else begin
        req_t e;
        e = exp_q.pop_front();
        if ({hcmd, hsub, hparam, hdata} !== e) begin
          errors++;
          $display("FAIL R2/R3 request act=%h exp=%h", {hcmd, hsub, hparam, hdata}, e);
        end
      end
    end
    req_d = req;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1 cmd", 1'b0, 32'h0);
    rd("R1 data", 1'b1, 32'h0);
    chk("R1 req", {31'b0, req}, 32'h0);

    wr(1'b1, 32'h0000_A5A5);
    rd("R10 data", 1'b1, 32'h0000_A5A5);

    wr(1'b0, 32'h7234_5678);
    rd("R4 cmd", 1'b0, 32'h3234_5678);
    chk("R4 req", {31'b0, req}, 32'h0);

    start(32'h1111_2222, 32'hAABC_5A3C);
    rd("R2 cmd busy", 1'b0, 32'hAABC_5A3C);
    chk("R2 req", {31'b0, req}, 32'h1);
    chk("R3 hdata", hdata, 32'h1111_2222);

    wr(1'b1, 32'h0000_DEAD);
    wr(1'b0, 32'h8000_0001);
    rd("R8 cmd", 1'b0, 32'hAABC_5A3C);
    rd("R8 data", 1'b1, 32'h1111_2222);

    do_ack(8'h00, 32'hCAFE_F00D);
    rd("R5 cmd", 1'b0, 32'h2ABC_5A00);
    chk("R5 req", {31'b0, req}, 32'h0);
    rd("R6 data", 1'b1, 32'hCAFE_F00D);

    do_ack(8'h07, 32'h0000_0123);
    rd("R9 cmd", 1'b0, 32'h2ABC_5A00);
    rd("R9 data", 1'b1, 32'hCAFE_F00D);

    start(32'h0000_4444, 32'h8001_1107);
    do_ack(8'h55, 32'h0000_BEEF);
    rd("R7 cmd", 1'b0, 32'h0001_1155);
    rd("R7 data", 1'b1, 32'h0000_4444);

    // completion and doorbell write in the same cycle
    start(32'h0000_0001, 32'h8000_0002);
    @(negedge clk);
    ack = 1'b1; code = 8'h00; resp = 32'h0000_0077;
    we = 1'b1; addr = 1'b0; wdata = 32'h8000_00FF;
    @(negedge clk);
    ack = 1'b0; we = 1'b0;
    rd("R8 same-cycle cmd", 1'b0, 32'h0000_0000);
    rd("R8 same-cycle data", 1'b1, 32'h0000_0077);
    chk("R8 same-cycle req", {31'b0, req}, 32'h0);
    repeat (2) @(negedge clk);
    chk("R2 queue drained", exp_q.size(), 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule